// File: doc/BRIEF.md
# Keyed Watchdog Sequencer

This block is the watchdog personality of a 64-bit timer. Software selects the watchdog mode in a small mode register and sets a sticky enable bit. It then arms the watchdog with a two-step key handshake: a write of the arming key 0xA5C6 and then the run key 0xDA7E. Once running, the 64-bit counter climbs by one every clock. Software keeps the system alive by repeating the same two keys, which restarts the counter from zero. If the counter meets the 64-bit period, or if software writes any key other than the two valid ones while the watchdog runs, the block drives a reset request for a fixed number of cycles. After that pulse it returns to its idle state.

Writes arrive on a valid/ready channel. A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops for the whole reset pulse. A master must then hold `wr_valid`, `wr_addr` and `wr_data` steady until the pulse ends. At every other time `wr_ready` is high. Reads are combinational from `rd_addr` to `rd_data`.

The register map uses word indices. 0 and 1 hold the counter's low and high 32 bits. 2 and 3 hold the period's low and high 32 bits. 4 is the mode register, with the mode in bits 1:0. 5 is the watchdog control register. Any other index reads as zero.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, all registers read zero, `wd_rst_o` is low and `wr_ready` is high. The control register holds the state in bits 2:0, with these codes: idle=0, enabled=1, pre-armed=2, running=3, service-pending=4, firing=5. The enable bit is bit 14, and its reset value is 0.
- R2: Writes to the control register (index 5) have no effect unless the mode field (index 4, bits 1:0) holds 2, the watchdog mode.
- R3: In watchdog mode, a control write with bit 14 set makes the enable bit 1. After that, a write of 0 to bit 14 leaves it at 1, and writes to the mode register are ignored.
- R4: In idle or enabled state, a control write of key 0xA5C6 (bits 31:16) with bit 14 set moves to pre-armed. The same key with bit 14 clear is ignored. Any other key with bit 14 set gives state enabled.
- R5: In pre-armed state, key 0xDA7E moves to running, and other keys are ignored. While running, the counter rises by one per clock, starting from its value at arming.
- R6: While running or service-pending, a control write whose key is neither 0xA5C6 nor 0xDA7E puts `wd_rst_o` high from the next cycle, with state firing. Key 0xDA7E alone while running changes nothing.
- R7: In running state, key 0xA5C6 moves to service-pending, and the counter keeps counting. Key 0xDA7E then reads the counter as 0 after the accepting edge and returns to running.
- R8: While running, when the counter equals the period, `wd_rst_o` rises. With the counter at 0 and the period at P when 0xDA7E is accepted, it goes high P+1 cycles after that edge.
- R9: `wd_rst_o` stays high for exactly PULSE_LEN cycles (default 16), with `wr_ready` low. The state is then idle and the enable bit remains 1.
- R10: Each 32-bit half of the counter and the period is written and read back independently at its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high with wr_valid; low during the reset pulse |
| wr_addr | input | ADDR_W | Register word index for the write |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | ADDR_W | Register word index for the read |
| rd_data | output | BUS_W | Read data, combinational from rd_addr |
| wd_rst_o | output | 1 | Reset request pulse |

## Verification
The hardest situations to reach are the exact timeout cycle and the service handshake while the counter runs, since the counter is internal and moves every clock. The stimulus clears the counter, loads a small period over the bus, and counts falling edges from the accepted run key until the reset pulse appears. It then measures the pulse width. A second arming uses a long period, so the service keys can be interleaved with counter readbacks taken a known number of cycles apart. An invalid key is then used to reach the firing state without waiting.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_ENABLED = 3'd1,
    WS_PRE     = 3'd2,
    WS_ACTIVE  = 3'd3,
    WS_SERVICE = 3'd4,
    WS_FIRE    = 3'd5
  } wd_state_e;

  localparam int unsigned KEY_W     = 16;
  localparam int unsigned WD_EN_BIT = 14;
  localparam logic [1:0]  MODE_WDOG = 2'd2;
endpackage

// File: rtl/wdg_decode.sv
module wdg_decode #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NHALF  = 2
) (
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  output logic [NHALF-1:0]  cnt_we,
  output logic [NHALF-1:0]  prd_we,
  output logic              mode_we,
  output logic              ctl_we
);
  localparam int unsigned A_MODE = 2 * NHALF;
  localparam int unsigned A_CTL  = 2 * NHALF + 1;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign cnt_we[h] = acc && (addr == ADDR_W'(h));
    assign prd_we[h] = acc && (addr == ADDR_W'(NHALF + h));
  end

  assign mode_we = acc && (addr == ADDR_W'(A_MODE));
  assign ctl_we  = acc && (addr == ADDR_W'(A_CTL));
endmodule

// File: rtl/wdg_wide_reg.sv
module wdg_wide_reg #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned NHALF  = 2,
  parameter bit          COUNTS = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NHALF-1:0]       we,
  input  logic [BUS_W-1:0]       wdata,
  input  logic                   clr,
  input  logic                   inc,
  output logic [NHALF*BUS_W-1:0] value
);
  localparam int unsigned W = NHALF * BUS_W;

  logic [W-1:0] q, q_n, step;

  if (COUNTS) begin : g_count
    assign step = q + W'(1);
  end else begin : g_hold
    assign step = q;
  end

  always_comb begin
    q_n = q;
    if (clr) begin
      q_n = '0;
    end else if (|we) begin
      for (int h = 0; h < NHALF; h++) begin
        if (we[h]) q_n[h*BUS_W +: BUS_W] = wdata;
      end
    end else if (inc) begin
      q_n = step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  assign value = q;
endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm import wdg_pkg::*; #(
  parameter int unsigned  PULSE_LEN = 16,
  parameter logic [15:0]  KEY_ARM   = 16'hA5C6,
  parameter logic [15:0]  KEY_RUN   = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             mode_we,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  input  logic [1:0]       mode_val,
  input  logic             timeout,
  output wd_state_e        st_q,
  output logic             en_q,
  output logic [1:0]       mode_q,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             fire_o
);
  localparam int unsigned PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  wd_state_e      st_n;
  logic           en_n;
  logic [PW-1:0]  pcnt_q;
  logic           wd_on, is_arm, is_run, is_bad;

  assign wd_on  = (mode_q == MODE_WDOG);
  assign is_arm = (key == KEY_ARM);
  assign is_run = (key == KEY_RUN);
  assign is_bad = !is_arm && !is_run;

  always_comb begin
    st_n    = st_q;
    en_n    = en_q;
    cnt_clr = 1'b0;
    unique case (st_q)
      WS_IDLE, WS_ENABLED: begin
        if (ctl_we && wd_on && en_bit) begin
          en_n = 1'b1;
          st_n = is_arm ? WS_PRE : WS_ENABLED;
        end
      end
      WS_PRE: begin
        if (ctl_we && wd_on && is_run) st_n = WS_ACTIVE;
      end
      WS_ACTIVE: begin
        if (timeout || (ctl_we && is_bad)) st_n = WS_FIRE;
        else if (ctl_we && is_arm)         st_n = WS_SERVICE;
      end
      WS_SERVICE: begin
        if (timeout || (ctl_we && is_bad)) begin
          st_n = WS_FIRE;
        end else if (ctl_we && is_run) begin
          st_n    = WS_ACTIVE;
          cnt_clr = 1'b1;
        end
      end
      WS_FIRE: begin
        if (pcnt_q == '0) st_n = WS_IDLE;
      end
      default: st_n = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      en_q   <= 1'b0;
      mode_q <= 2'd0;
      pcnt_q <= '0;
    end else begin
      st_q <= st_n;
      en_q <= en_n;
      if (mode_we && !en_q) mode_q <= mode_val;
      if (st_n == WS_FIRE && st_q != WS_FIRE) pcnt_q <= PW'(PULSE_LEN - 1);
      else if (st_q == WS_FIRE && pcnt_q != '0) pcnt_q <= pcnt_q - PW'(1);
    end
  end

  assign cnt_inc = (st_q == WS_ACTIVE) || (st_q == WS_SERVICE);
  assign fire_o  = (st_q == WS_FIRE);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top import wdg_pkg::*; #(
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [15:0] KEY_ARM   = 16'hA5C6,
  parameter logic [15:0] KEY_RUN   = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              wd_rst_o
);
  localparam int unsigned NHALF   = CNT_W / BUS_W;
  localparam int unsigned KEY_LSB = BUS_W - KEY_W;
  localparam int unsigned A_MODE  = 2 * NHALF;
  localparam int unsigned A_CTL   = 2 * NHALF + 1;

  logic             acc;
  logic [NHALF-1:0] cnt_we, prd_we;
  logic             mode_we, ctl_we;
  logic [CNT_W-1:0] cnt_q, prd_q;
  logic             cnt_clr, cnt_inc, timeout, fire;
  wd_state_e        st_q;
  logic             en_q;
  logic [1:0]       mode_q;

  assign acc      = wr_valid && wr_ready;
  assign wr_ready = (st_q != WS_FIRE);
  assign timeout  = (cnt_q == prd_q);
  assign wd_rst_o = fire;

  wdg_decode #(.ADDR_W(ADDR_W), .NHALF(NHALF)) u_dec (
    .acc(acc), .addr(wr_addr), .cnt_we(cnt_we), .prd_we(prd_we),
    .mode_we(mode_we), .ctl_we(ctl_we)
  );

  wdg_wide_reg #(.BUS_W(BUS_W), .NHALF(NHALF), .COUNTS(1'b1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .we(cnt_we), .wdata(wr_data),
    .clr(cnt_clr), .inc(cnt_inc), .value(cnt_q)
  );

  wdg_wide_reg #(.BUS_W(BUS_W), .NHALF(NHALF), .COUNTS(1'b0)) u_prd (
    .clk(clk), .rst_n(rst_n), .we(prd_we), .wdata(wr_data),
    .clr(1'b0), .inc(1'b0), .value(prd_q)
  );

  wdg_key_fsm #(.PULSE_LEN(PULSE_LEN), .KEY_ARM(KEY_ARM), .KEY_RUN(KEY_RUN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .mode_we(mode_we),
    .key(wr_data[KEY_LSB +: KEY_W]), .en_bit(wr_data[WD_EN_BIT]),
    .mode_val(wr_data[1:0]), .timeout(timeout),
    .st_q(st_q), .en_q(en_q), .mode_q(mode_q),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .fire_o(fire)
  );

  always_comb begin
    rd_data = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (rd_addr == ADDR_W'(h))         rd_data = cnt_q[h*BUS_W +: BUS_W];
      if (rd_addr == ADDR_W'(NHALF + h)) rd_data = prd_q[h*BUS_W +: BUS_W];
    end
    if (rd_addr == ADDR_W'(A_MODE)) rd_data[1:0] = mode_q;
    if (rd_addr == ADDR_W'(A_CTL)) begin
      rd_data[WD_EN_BIT] = en_q;
      rd_data[2:0]       = st_q;
    end
  end
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk import wdg_pkg::*; #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned A_CTL     = 5,
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [15:0] KEY_ARM   = 16'hA5C6,
  parameter logic [15:0] KEY_RUN   = 16'hDA7E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [KEY_W-1:0]  key,
  input logic              wd_rst_o,
  input logic [2:0]        st,
  input logic              en,
  input logic [1:0]        mode
);
  localparam int unsigned RW = $clog2(PULSE_LEN + 1);

  logic [RW-1:0] run_q;
  logic          ctl_acc, live, bad_key;

  assign ctl_acc = wr_valid && wr_ready && (wr_addr == ADDR_W'(A_CTL));
  assign live    = (st == WS_ACTIVE) || (st == WS_SERVICE);
  assign bad_key = (key != KEY_ARM) && (key != KEY_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (wd_rst_o) run_q <= run_q + RW'(1);
    else               run_q <= '0;
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> run_q < RW'(PULSE_LEN));                                   // R9
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_o) |-> run_q == RW'(PULSE_LEN));                           // R9
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> !wr_ready);                                                // R9
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_o) |-> st == WS_IDLE);                                     // R9
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);                                                             // R3
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && mode != MODE_WDOG) |=> !en);                                    // R2
  AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && live && bad_key) |=> wd_rst_o);                             // R6
endmodule

bind wdg_keyed_top wdg_keyed_chk #(
  .ADDR_W(ADDR_W), .A_CTL(A_CTL), .PULSE_LEN(PULSE_LEN),
  .KEY_ARM(KEY_ARM), .KEY_RUN(KEY_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .key(wr_data[KEY_LSB +: KEY_W]), .wd_rst_o(wd_rst_o),
  .st(st_q), .en(en_q), .mode(mode_q)
);

// File: tb/test_wdg_keyed_top.sv
`timescale 1ns/1ps
module test_wdg_keyed_top;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        wd_rst_o;

  int total = 0;
  int bad   = 0;

  always #(CYC/2) clk = ~clk;

  wdg_keyed_top i_wdg_keyed_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wd_rst_o(wd_rst_o)
  );

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] data;
    logic [2:0]  st;
    logic        en;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd5, 32'hA5C6_4000, 3'd0, 1'b0, 4'd2},  // R2 mode still 0
    '{3'd4, 32'h0000_0002, 3'd0, 1'b0, 4'd2},  // R2 select watchdog mode
    '{3'd5, 32'h0000_0000, 3'd0, 1'b0, 4'd3},  // R3 no enable bit
    '{3'd5, 32'hA5C6_0000, 3'd0, 1'b0, 4'd4},  // R4 key without enable bit
    '{3'd5, 32'h0000_4000, 3'd1, 1'b1, 4'd3},  // R3 enable
    '{3'd5, 32'h0000_0000, 3'd1, 1'b1, 4'd3},  // R3 enable sticky
    '{3'd5, 32'hDA7E_4000, 3'd1, 1'b1, 4'd4},  // R4 run key first
    '{3'd5, 32'hA5C6_4000, 3'd2, 1'b1, 4'd4},  // R4 pre-armed
    '{3'd5, 32'h1234_4000, 3'd2, 1'b1, 4'd5}   // R5 stray key ignored
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, c1, c2;
    int n, len;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register reset value", d, 0);
    end
    chk("R1 reset output low", wd_rst_o, 0);
    chk("R1 ready high", wr_ready, 1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].addr, VEC[i].data);
      rd(3'd5, d);
      chk($sformatf("R%0d vector %0d state", VEC[i].req, i), d[2:0], VEC[i].st);
      chk($sformatf("R%0d vector %0d enable", VEC[i].req, i), d[14], VEC[i].en);
    end

    wr(3'd4, 32'h0);
    rd(3'd4, d);
    chk("R3 mode locked", d[1:0], 2);

    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h0000_0001);
    wr(3'd2, 32'hCAFE_0001); wr(3'd3, 32'h0000_0007);
    rd(3'd0, d); chk("R10 counter low", d, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R10 counter high", d, 1);
    rd(3'd2, d); chk("R10 period low", d, 32'hCAFE_0001);
    rd(3'd3, d); chk("R10 period high", d, 7);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd3, 0); wr(3'd2, 20);

    wr(3'd5, 32'hDA7E_0000);
    rd(3'd5, d); chk("R5 running", d[2:0], 3);
    rd(3'd0, d); chk("R5 counter at arming", d, 0);
    n = 0;
    while (!wd_rst_o && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 5) begin
        rd(3'd0, d);
        chk("R5 counter after 5 cycles", d, 5);
      end
    end
    chk("R8 timeout cycle", n, 21);
    chk("R9 ready low in pulse", wr_ready, 0);
    len = 0;
    while (wd_rst_o && len < 100) begin
      len++;
      @(negedge clk);
    end
    chk("R9 pulse length", len, 16);
    rd(3'd5, d);
    chk("R9 idle after pulse", d[2:0], 0);
    chk("R9 enable kept", d[14], 1);
    chk("R9 ready back", wr_ready, 1);

    wr(3'd0, 0); wr(3'd2, 1000);
    wr(3'd5, 32'hA5C6_4000);
    wr(3'd5, 32'hDA7E_0000);
    rd(3'd5, d); chk("R5 rearmed", d[2:0], 3);
    repeat (3) @(negedge clk);
    wr(3'd5, 32'hA5C6_0000);
    rd(3'd5, d); chk("R7 service pending", d[2:0], 4);
    rd(3'd0, c1);
    @(negedge clk); @(negedge clk);
    rd(3'd0, c2);
    chk("R7 counting while pending", c2, c1 + 2);
    wr(3'd5, 32'hDA7E_0000);
    rd(3'd5, d); chk("R7 back to running", d[2:0], 3);
    rd(3'd0, d); chk("R7 counter restarted", d, 0);
    wr(3'd5, 32'hDA7E_0000);
    rd(3'd5, d); chk("R6 lone run key no effect", d[2:0], 3);
    rd(3'd0, d); chk("R6 counter not cleared", d, 2);
    chk("R6 no reset on valid key", wd_rst_o, 0);
    wr(3'd5, 32'h0000_4000);
    chk("R6 bad key fires", wd_rst_o, 1);
    rd(3'd5, d); chk("R6 firing state", d[2:0], 5);
    n = 0;
    while (wd_rst_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9 pulse after bad key", n, 16);
    finish_run();
  end
endmodule